// File: doc/BRIEF.md
# Translation Table Update Engine

This block owns one table of address translation entries and serves commands that change or inspect it. A command carries a 64-bit table identifier, a bus address, a data word and an entry count. Four operations exist. A single write stores a value. A single read returns a stored value. A fill stores one value into a run of consecutive pages. A list write stores a run of entries that the engine fetches one by one through a simple memory-read port. Every command ends with exactly one response pulse that reports success or a parameter error.

The identifier, the base bus offset, the page shift and the entry count are parameters. The bus address of a command is rounded down to its page before it is converted to a table index. Multi-entry commands step one page per entry. They stop at the first entry that falls outside the table and report the error, and entries written before that point keep their new values. Each stored entry is announced on an invalidate output, so that downstream translation caches can drop stale copies. While a multi-entry command runs, the engine shows busy and ignores new commands.

Top module: `xlt_update_engine`

## Requirements
- R1: A command whose identifier has any bit of [63:32] set, or whose low 32 bits differ from TABLE_ID, returns an error response and changes no entry.
- R2: Op code 0 (single write) clears the page-offset bits of cmd_addr and forms index = (page address - BUS_OFFSET) >> PAGE_SHIFT. It stores cmd_data at that index and responds with success one cycle after acceptance.
- R3: An index at or beyond N_ENTRIES, including an address below BUS_OFFSET, gives an error response and no write.
- R4: Op code 1 (single read) returns the stored entry unchanged in rsp_data with success. On any error response, rsp_data is zero.
- R5: Op code 2 (fill) with a count of zero, or a count above N_ENTRIES, is rejected with no write. Otherwise it stores cmd_data into count consecutive pages, starting at the page of cmd_addr.
- R6: Op code 3 (list write) is rejected with no memory read when the count is zero, when the count is above 512, or when cmd_data (the list address) has any of bits [11:0] set.
- R7: A list write reads entry i from list address + 8*i with a one-cycle mem_req pulse. Within mem_rdata, the byte at the lowest address sits in bits [7:0]. The stored entry treats that byte as the most significant byte.
- R8: A fill or list write that reaches an out-of-range index stops there with an error. It keeps the entries already written and issues no further memory reads.
- R9: Every entry write pulses inval_valid for one cycle, with inval_addr equal to the page-aligned bus address of that entry.
- R10: busy is high from acceptance of a fill or list write until its response. A command presented while busy is ignored.
- R11: Reset zeroes every table entry and drives busy, rsp_valid, inval_valid and mem_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list write |
| cmd_id | input | 64 | Table identifier |
| cmd_addr | input | 64 | Bus address of the first entry |
| cmd_data | input | 64 | Entry value, or list address for op 3 |
| cmd_count | input | CNT_W | Entry count for ops 2 and 3 |
| busy | output | 1 | Multi-entry command in progress |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Parameter error flag of the response |
| rsp_data | output | 64 | Entry read by op 1, zero otherwise |
| inval_valid | output | 1 | Entry written this cycle |
| inval_addr | output | 64 | Page-aligned bus address of that entry |
| mem_req | output | 1 | List word read request |
| mem_addr | output | 64 | Address of the requested list word |
| mem_rvalid | input | 1 | List word returned |
| mem_rdata | input | 64 | Returned list word, lowest-address byte in [7:0] |

## Verification
Single writes and reads are sent with page-offset bits set and with addresses on both sides of the table bounds. This separates correct rounding and offset subtraction from off-by-one bound checks. Fills and list writes are run fully inside the table and also straddling its last entry, which shows whether the stop is early and whether the earlier writes are kept. A list of byte-asymmetric words exposes any swapped byte order. Malformed identifiers, zero counts, oversized counts and misaligned list addresses each must produce only an error. A write presented during a fill must leave no trace.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_FILL  = 2'd2,
    OP_LIST  = 2'd3
  } xlt_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_LREQ  = 2'd2,
    ST_LWAIT = 2'd3
  } xlt_state_e;

endpackage

// File: rtl/xlt_index.sv
module xlt_index #(
  parameter logic [63:0] BUS_OFFSET = 64'h0000_0000_8000_0000,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned N_ENTRIES  = 64,
  parameter int unsigned IDX_W      = 6
) (
  input  logic [63:0]      addr,
  output logic [63:0]      page_addr,
  output logic [IDX_W-1:0] idx,
  output logic             in_range
);
  localparam logic [63:0] OFF_MASK = (64'd1 << PAGE_SHIFT) - 64'd1;
  localparam logic [63:0] LIMIT    = 64'(N_ENTRIES);

  logic [63:0] rel;
  logic [63:0] pg;

  always_comb begin
    page_addr = addr & ~OFF_MASK;
    rel       = page_addr - BUS_OFFSET;
    pg        = rel >> PAGE_SHIFT;
    in_range  = (pg < LIMIT);
    idx       = pg[IDX_W-1:0];
  end
endmodule

// File: rtl/xlt_cmd_check.sv
module xlt_cmd_check
  import xlt_pkg::*;
#(
  parameter logic [31:0] TABLE_ID   = 32'h8000_0011,
  parameter int unsigned N_ENTRIES  = 64,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned LIST_MAX   = 512,
  parameter int unsigned LIST_ALIGN = 12
) (
  input  xlt_op_e               op,
  input  logic [63:0]           id,
  input  logic [CNT_W-1:0]      count,
  input  logic [LIST_ALIGN-1:0] list_lo,
  output logic                  id_ok,
  output logic                  bulk_reject
);
  localparam logic [CNT_W-1:0] FILL_LIM = CNT_W'(N_ENTRIES);
  localparam logic [CNT_W-1:0] LIST_LIM = CNT_W'(LIST_MAX);

  logic fill_bad;
  logic list_bad;
  logic cnt_zero;

  always_comb begin
    id_ok    = (id[63:32] == 32'd0) && (id[31:0] == TABLE_ID);
    cnt_zero = (count == '0);
    fill_bad = cnt_zero || (count > FILL_LIM);
    list_bad = cnt_zero || (count > LIST_LIM) || (list_lo != '0);
    unique case (op)
      OP_FILL: bulk_reject = !id_ok || fill_bad;
      OP_LIST: bulk_reject = !id_ok || list_bad;
      default: bulk_reject = !id_ok;
    endcase
  end
endmodule

// File: rtl/xlt_table.sv
module xlt_table #(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned DW        = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] ent [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic          hit;
    logic [DW-1:0] q;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign ent[g] = q;
  end

  // rd_idx is only consumed by the caller when it lies inside the table
  assign rd_data = ent[rd_idx];
endmodule

// File: rtl/xlt_update_engine.sv
module xlt_update_engine
  import xlt_pkg::*;
#(
  parameter logic [31:0] TABLE_ID   = 32'h8000_0011,
  parameter logic [63:0] BUS_OFFSET = 64'h0000_0000_8000_0000,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned N_ENTRIES  = 64,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned LIST_MAX   = 512,
  parameter int unsigned LIST_ALIGN = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [63:0]      cmd_id,
  input  logic [63:0]      cmd_addr,
  input  logic [63:0]      cmd_data,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [63:0]      rsp_data,
  output logic             inval_valid,
  output logic [63:0]      inval_addr,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata
);
  localparam int unsigned IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam logic [63:0] PAGE_SIZE = 64'd1 << PAGE_SHIFT;
  localparam logic [63:0] WORD_STEP = 64'd8;
  localparam int unsigned NBYTES    = 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  xlt_state_e       st_q, st_d;
  logic [63:0]      cur_q, cur_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [63:0]      ptr_q, ptr_d;
  logic [63:0]      val_q, val_d;
  logic             ctx_en;
  logic             rsp_v_q, rsp_v_d;
  logic             rsp_e_q, rsp_e_d;
  logic [63:0]      rsp_dat_q, rsp_dat_d;
  logic             inv_v_q, inv_v_d;
  logic [63:0]      inv_a_q, inv_a_d;

  xlt_op_e          op;
  logic [63:0]      ix_addr;
  logic [63:0]      ix_page;
  logic [IDX_W-1:0] ix_idx;
  logic             ix_ok;
  logic             id_ok;
  logic             bulk_reject;
  logic             tbl_we;
  logic [63:0]      tbl_wd;
  logic [63:0]      tbl_rd;
  logic [63:0]      swapped;
  logic             step_go;

  assign op      = xlt_op_e'(cmd_op);
  assign ix_addr = (st_q == ST_IDLE) ? cmd_addr : cur_q;

  // list words arrive lowest-address byte first; entries are big-endian
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign swapped[8*b +: 8] = mem_rdata[8*(NBYTES-1-b) +: 8];
  end

  xlt_index #(
    .BUS_OFFSET(BUS_OFFSET), .PAGE_SHIFT(PAGE_SHIFT),
    .N_ENTRIES(N_ENTRIES),   .IDX_W(IDX_W)
  ) u_index (
    .addr(ix_addr), .page_addr(ix_page), .idx(ix_idx), .in_range(ix_ok)
  );

  xlt_cmd_check #(
    .TABLE_ID(TABLE_ID), .N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W),
    .LIST_MAX(LIST_MAX), .LIST_ALIGN(LIST_ALIGN)
  ) u_check (
    .op(op), .id(cmd_id), .count(cmd_count),
    .list_lo(cmd_data[LIST_ALIGN-1:0]),
    .id_ok(id_ok), .bulk_reject(bulk_reject)
  );

  xlt_table #(
    .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .DW(64)
  ) u_table (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(tbl_we), .wr_idx(ix_idx), .wr_data(tbl_wd),
    .rd_idx(ix_idx), .rd_data(tbl_rd)
  );

  assign step_go = (st_q == ST_FILL) || ((st_q == ST_LWAIT) && mem_rvalid);

  // next-state logic
  always_comb begin
    st_d      = st_q;
    ctx_en    = 1'b0;
    cur_d     = cur_q;
    rem_d     = rem_q;
    ptr_d     = ptr_q;
    val_d     = val_q;
    rsp_v_d   = 1'b0;
    rsp_e_d   = 1'b0;
    rsp_dat_d = '0;
    inv_v_d   = 1'b0;
    inv_a_d   = ix_page;
    tbl_we    = 1'b0;
    tbl_wd    = cmd_data;

    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          unique case (op)
            OP_WRITE: begin
              rsp_v_d = 1'b1;
              if (!id_ok || !ix_ok) begin
                rsp_e_d = 1'b1;
              end else begin
                tbl_we  = 1'b1;
                inv_v_d = 1'b1;
              end
            end
            OP_READ: begin
              rsp_v_d = 1'b1;
              if (!id_ok || !ix_ok) rsp_e_d   = 1'b1;
              else                  rsp_dat_d = tbl_rd;
            end
            OP_FILL, OP_LIST: begin
              if (bulk_reject) begin
                rsp_v_d = 1'b1;
                rsp_e_d = 1'b1;
              end else begin
                ctx_en = 1'b1;
                cur_d  = ix_page;
                rem_d  = cmd_count;
                val_d  = cmd_data;
                ptr_d  = cmd_data;
                st_d   = (op == OP_FILL) ? ST_FILL : ST_LREQ;
              end
            end
            default: ;
          endcase
        end
      end
      ST_LREQ: st_d = ST_LWAIT;
      default: ;
    endcase

    if (step_go) begin
      tbl_wd = (st_q == ST_FILL) ? val_q : swapped;
      if (!ix_ok) begin
        rsp_v_d = 1'b1;
        rsp_e_d = 1'b1;
        st_d    = ST_IDLE;
      end else begin
        tbl_we  = 1'b1;
        inv_v_d = 1'b1;
        ctx_en  = 1'b1;
        cur_d   = cur_q + PAGE_SIZE;
        rem_d   = rem_q - CNT_W'(1);
        ptr_d   = ptr_q + WORD_STEP;
        if (rem_q == CNT_W'(1)) begin
          rsp_v_d = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          st_d = (st_q == ST_FILL) ? ST_FILL : ST_LREQ;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q      <= ST_IDLE;
      rsp_v_q   <= 1'b0;
      rsp_e_q   <= 1'b0;
      rsp_dat_q <= '0;
      inv_v_q   <= 1'b0;
      inv_a_q   <= '0;
    end else begin
      st_q      <= st_d;
      rsp_v_q   <= rsp_v_d;
      rsp_e_q   <= rsp_e_d;
      rsp_dat_q <= rsp_dat_d;
      inv_v_q   <= inv_v_d;
      inv_a_q   <= inv_a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cur_q <= '0;
      rem_q <= '0;
      ptr_q <= '0;
      val_q <= '0;
    end else if (ctx_en) begin
      cur_q <= cur_d;
      rem_q <= rem_d;
      ptr_q <= ptr_d;
      val_q <= val_d;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign rsp_valid   = rsp_v_q;
  assign rsp_err     = rsp_e_q;
  assign rsp_data    = rsp_dat_q;
  assign inval_valid = inv_v_q;
  assign inval_addr  = inv_a_q;
  assign mem_req     = (st_q == ST_LREQ);
  assign mem_addr    = ptr_q;

  // R4: error responses never carry entry data
  p_err_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rsp_valid && rsp_err) |-> (rsp_data == 64'd0));

  // R7: each list word request lasts exactly one cycle
  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req |=> !mem_req);

  // R8: nothing is written while a list word is still outstanding
  p_wait_quiet_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((st_q == ST_LWAIT) && !mem_rvalid) |=> !inval_valid);

  // R9: invalidate addresses are page aligned
  p_inval_page_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    inval_valid |-> (inval_addr[PAGE_SHIFT-1:0] == '0));

  // R10: a response always leaves the engine idle
  p_idle_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |-> !busy);
endmodule

// File: tb/xlt_update_engine_bench.sv
`timescale 1ns/1ps
module xlt_update_engine_bench;
  localparam logic [31:0] TID   = 32'h8000_0011;
  localparam logic [63:0] BOFF  = 64'h0000_0000_8000_0000;
  localparam int          NENT  = 64;
  localparam logic [63:0] PG    = 64'h1000;
  localparam logic [63:0] LBASE = 64'h0000_0000_0004_0000;
  localparam logic [63:0] GID   = {32'd0, TID};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [63:0] cmd_id = '0, cmd_addr = '0, cmd_data = '0;
  logic [15:0] cmd_count = '0;
  logic        busy, rsp_valid, rsp_err, inval_valid, mem_req;
  logic [63:0] rsp_data, inval_addr, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #4 clk = ~clk;

  xlt_update_engine u_xlt_update_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_count(cmd_count), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .inval_valid(inval_valid),
    .inval_addr(inval_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int tests = 0, fails = 0;
  logic [63:0] ref_tab [NENT];
  logic [63:0] lmem [16];
  logic [63:0] exp_inv[$];
  logic [63:0] exp_mem[$];
  logic        exp_err;
  logic [63:0] exp_dat;
  string       cur_tag = "R11";
  bit          got_rsp;
  int          n_rsp;
  bit          mem_delay = 0;
  logic [63:0] mem_word;
  int          cycles = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] bswap(logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = w[8*(7-b) +: 8];
    return r;
  endfunction

  function automatic bit idx_of(logic [63:0] a, output int ix, output logic [63:0] pa);
    logic [63:0] rel;
    pa  = a & ~(PG - 64'd1);
    rel = (pa - BOFF) / PG;
    ix  = int'(rel[7:0]);
    return rel < 64'(NENT);
  endfunction

  // behavioural reference: predicts invalidates, memory reads and the response
  task automatic model_cmd(logic [1:0] op, logic [63:0] id, logic [63:0] addr,
                           logic [63:0] data, int cnt);
    bit          idok, ok;
    int          ix;
    logic [63:0] pa, cur, w;
    idok    = (id[63:32] == 32'd0) && (id[31:0] == TID);
    exp_err = 1'b0;
    exp_dat = '0;
    exp_inv.delete();
    exp_mem.delete();
    ok = idx_of(addr, ix, pa);
    case (op)
      2'd0: if (!idok || !ok) exp_err = 1'b1;
            else begin ref_tab[ix] = data; exp_inv.push_back(pa); end
      2'd1: if (!idok || !ok) exp_err = 1'b1; else exp_dat = ref_tab[ix];
      2'd2: if (!idok || cnt == 0 || cnt > NENT) exp_err = 1'b1;
            else begin
              cur = pa;
              for (int i = 0; i < cnt; i++) begin
                if (!idx_of(cur, ix, pa)) begin exp_err = 1'b1; break; end
                ref_tab[ix] = data; exp_inv.push_back(pa); cur = cur + PG;
              end
            end
      default: if (!idok || cnt == 0 || cnt > 512 || data[11:0] != 12'd0) exp_err = 1'b1;
            else begin
              cur = pa;
              for (int i = 0; i < cnt; i++) begin
                exp_mem.push_back(data + 64'(8*i));
                w = lmem[((data - LBASE) >> 3) + 64'(i)];
                if (!idx_of(cur, ix, pa)) begin exp_err = 1'b1; break; end
                ref_tab[ix] = w; exp_inv.push_back(pa); cur = cur + PG;
              end
            end
    endcase
  endtask

  // per-clock comparison and list memory
  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid = 1'b0;
    if (mem_delay) begin
      mem_delay  = 0;
      mem_rvalid = 1'b1;
      mem_rdata  = bswap(mem_word);
    end
    if (rst_n) begin
      if (inval_valid) begin
        if (exp_inv.size() == 0) chk(cur_tag, 64'd1, 64'd0, "unexpected invalidate (R9)");
        else chk(cur_tag, inval_addr, exp_inv.pop_front(), "invalidate address (R9)");
      end
      if (mem_req) begin
        if (exp_mem.size() == 0) chk(cur_tag, 64'd1, 64'd0, "unexpected list read (R7)");
        else chk(cur_tag, mem_addr, exp_mem.pop_front(), "list read address (R7)");
        mem_word  = lmem[int'((mem_addr - LBASE) >> 3) & 15];
        mem_delay = 1;
      end
      if (rsp_valid) begin
        chk(cur_tag, 64'(rsp_err), 64'(exp_err), "response error flag");
        chk(cur_tag, rsp_data, exp_dat, "response data");
        n_rsp++;
        got_rsp = 1;
      end
    end
  end

  task automatic run_cmd(string tag, logic [1:0] op, logic [63:0] id, logic [63:0] addr,
                         logic [63:0] data, int cnt, bit poke);
    cur_tag = tag;
    model_cmd(op, id, addr, data, cnt);
    @(negedge clk);
    got_rsp = 0; n_rsp = 0;
    cmd_op = op; cmd_id = id; cmd_addr = addr; cmd_data = data; cmd_count = 16'(cnt);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      chk("R10", 64'(busy), 64'd1, "busy during fill");
      cmd_op = 2'd0; cmd_id = GID; cmd_addr = BOFF + 40*PG; cmd_data = 64'hDEAD_BEEF_0000_0040;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (!got_rsp) @(negedge clk);
    @(negedge clk);
    chk(tag, 64'(n_rsp), 64'd1, "response count");
    chk(tag, 64'(exp_inv.size()), 64'd0, "missing invalidates");
    chk(tag, 64'(exp_mem.size()), 64'd0, "missing list reads");
    chk(tag, 64'(busy), 64'd0, "busy after response");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NENT; i++) ref_tab[i] = '0;
    @(negedge clk);
    chk("R11", {60'd0, busy, rsp_valid, inval_valid, mem_req}, 64'd0, "outputs in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) lmem[i] = 64'h0123_4567_89AB_CD00 + 64'(i * 17);
    do_reset();
    run_cmd("R11", 2'd1, GID, BOFF + 3*PG, 0, 0, 0);
    // single write with page-offset bits, read back through another offset
    run_cmd("R2", 2'd0, GID, BOFF + 5*PG + 64'h123, 64'h1111_2222_3333_4445, 0, 0);
    run_cmd("R4", 2'd1, GID, BOFF + 5*PG + 64'hFF8, 0, 0, 0);
    run_cmd("R2", 2'd0, GID, BOFF, 64'hAAAA_0000_0000_0003, 0, 0);
    run_cmd("R1", 2'd0, GID | 64'h1_0000_0000, BOFF + 5*PG, 64'h99, 0, 0);
    run_cmd("R1", 2'd0, {32'd0, TID ^ 32'h1}, BOFF + 5*PG, 64'h99, 0, 0);
    run_cmd("R1", 2'd1, GID, BOFF + 5*PG, 0, 0, 0);
    run_cmd("R3", 2'd0, GID, BOFF + 64*PG, 64'h77, 0, 0);
    run_cmd("R3", 2'd0, GID, BOFF - PG, 64'h77, 0, 0);
    run_cmd("R3", 2'd0, GID, BOFF + 63*PG + 64'hABC, 64'h6363, 0, 0);
    run_cmd("R4", 2'd1, GID, BOFF + 64*PG, 0, 0, 0);
    // fill
    run_cmd("R5", 2'd2, GID, BOFF + 10*PG, 64'h55, 0, 0);
    run_cmd("R5", 2'd2, GID, BOFF, 64'h55, 65, 0);
    run_cmd("R5", 2'd2, GID, BOFF + 10*PG + 64'h10, 64'h0F0F_0000_0000_0001, 3, 0);
    run_cmd("R5", 2'd1, GID, BOFF + 12*PG, 0, 0, 0);
    run_cmd("R5", 2'd1, GID, BOFF + 13*PG, 0, 0, 0);
    run_cmd("R8", 2'd2, GID, BOFF + 62*PG, 64'hF1F1, 4, 0);
    run_cmd("R8", 2'd1, GID, BOFF + 63*PG, 0, 0, 0);
    // list write
    run_cmd("R6", 2'd3, GID, BOFF + 20*PG, LBASE, 0, 0);
    run_cmd("R6", 2'd3, GID, BOFF + 20*PG, LBASE, 513, 0);
    run_cmd("R6", 2'd3, GID, BOFF + 20*PG, LBASE + 64'h8, 2, 0);
    run_cmd("R7", 2'd3, GID, BOFF + 20*PG, LBASE, 3, 0);
    run_cmd("R7", 2'd1, GID, BOFF + 21*PG, 0, 0, 0);
    run_cmd("R7", 2'd1, GID, BOFF + 22*PG, 0, 0, 0);
    run_cmd("R8", 2'd3, GID, BOFF + 63*PG, LBASE, 3, 0);
    run_cmd("R8", 2'd1, GID, BOFF + 63*PG, 0, 0, 0);
    // command while busy must be ignored
    run_cmd("R10", 2'd2, GID, BOFF + 30*PG, 64'h3030, 4, 1);
    run_cmd("R10", 2'd1, GID, BOFF + 40*PG, 0, 0, 0);
    run_cmd("R10", 2'd1, GID, BOFF + 33*PG, 0, 0, 0);
    // reset clears the table
    do_reset();
    run_cmd("R11", 2'd1, GID, BOFF + 5*PG, 0, 0, 0);
    run_cmd("R11", 2'd1, GID, BOFF + 21*PG, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule